// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block models a synchronous static RAM with a built-in four-beat burst address generator and flow-through reads. Every command input (address, the three chip selects, the two address strobes, the advance input and the write controls) is captured on the rising clock edge. At each edge the block classifies the cycle as a deselect, a new burst, a burst step or a burst wait, and as a read or a write. Writes land in the array at that edge, over four 9-bit lanes. Reads come straight from the array at the registered address, with no output register, so read data is valid within the same clock period.

Two address strobes start bursts, and they follow different rules. The processor strobe needs the primary select active and always opens a read. A write to that same word can then be issued on the next wait cycle. The controller strobe opens a read or a write according to the write controls. A static mode input picks the order of the burst: a linear order or an XOR-interleaved order over the two low address bits. An asynchronous output enable and a sleep input gate the read data. The bidirectional data bus is split into a data-in bus, a data-out bus and a drive-enable flag.

Top module: `fts_burst_sram`

## Requirements
- R1: The chip counts as selected only when `selN`=0, `selHi`=1 and `selLoN`=0. A controller strobe (`ctrlStrobeN`=0) or a processor strobe taken with `selN`=0 while the chip is not selected is a deselect cycle. It writes nothing, and `dataOutEn` is 0 from that edge until a later strobe opens a new burst.
- R2: With `selN`=1 the processor strobe is ignored. If `ctrlStrobeN`=1, the cycle is handled as a burst step or a burst wait.
- R3: A processor strobe with the chip selected opens a read burst at `addr`, even when the write controls request a write. The data word presented in that cycle is not stored.
- R4: A controller strobe with the processor strobe not taken and the chip selected opens a burst at `addr`. The burst starts as a write when the write controls request one, and as a read otherwise.
- R5: With both strobes inactive in an open burst, `advanceN`=0 moves to the next word. The upper address bits do not change. With `linearMode`=1 the two low bits go start+k (mod 4). With `linearMode`=0 they go start XOR k, where k counts the beats 0,1,2,3 and then wraps.
- R6: With both strobes inactive in an open burst, `advanceN`=1 stays on the current word. A write on such a wait cycle straight after a processor-strobe read stores to the read address.
- R7: Write controls: `globalWrN`=0 writes all four lanes. Otherwise `laneWrEnN`=0 writes each lane n whose `laneWrN[n]`=0, and no lane bit low means a read. Lane n holds data bits [8n+7:8n] and parity bit 32+n.
- R8: Read data for a read cycle started at clock edge k appears on `dataOut`, with `dataOutEn`=1, before edge k+1.
- R9: `dataOutEn` is 0 and `dataOut` is all zeros during a write cycle, when deselected, or while `outEnN`=1. `outEnN` acts at once, with no clock edge.
- R10: While `sleep`=1, commands are ignored and `dataOutEn` is 0. Array contents are kept. After `sleep` returns to 0, the burst is closed until a new strobe.
- R11: While `rstN`=0 and after it, the block is deselected with `dataOutEn`=0 until a strobe opens a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| selN | input | 1 | Primary select, active low; also gates the processor strobe |
| selHi | input | 1 | Secondary select, active high |
| selLoN | input | 1 | Secondary select, active low |
| procStrobeN | input | 1 | Processor address strobe, active low; always opens a read |
| ctrlStrobeN | input | 1 | Controller address strobe, active low; opens a read or a write |
| advanceN | input | 1 | Burst advance, active low; high holds the current word |
| globalWrN | input | 1 | Write all lanes, active low |
| laneWrEnN | input | 1 | Enable for the per-lane write inputs, active low |
| laneWrN | input | 4 | Per-lane write requests, active low |
| linearMode | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Standby request, active high |
| addr | input | ADDR_W | Word address for a new burst |
| dataIn | input | 36 | Write data: four bytes in [31:0], four parity bits in [35:32] |
| dataOut | output | 36 | Read data; zero when not driven |
| dataOutEn | output | 1 | Drive enable for the data bus |

## Verification
A wrong burst offset or base shows up as a wrong word on `dataOut` within the same period as the edge that advanced the burst. A burst-open flag stuck high shows up right after a deselect or a sleep edge, as `dataOutEn` asserted in the next period. A wrong lane mask or write gate is invisible at the write itself, because the outputs are off then. It shows only when the word is read back later, so every write scenario ends with a read of the affected words.

// File: rtl/fts_pkg.sv
package fts_pkg;

  // Number of 9-bit byte lanes in one word.
  localparam int LANE_CNT = 4;
  // The burst generator walks the low address bits only.
  localparam int BURST_BITS = 2;

  // Per-edge orders from the control to the datapath.
  typedef struct packed {
    logic                loadBase;  // capture external address, clear beat count
    logic                stepCount; // move to the next beat of the burst
    logic                writeNow;  // store lanes at the effective address
    logic [LANE_CNT-1:0] laneSel;   // lanes taking part in the write
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_OPEN_PROC,
    CYC_OPEN_CTRL,
    CYC_STEP,
    CYC_WAIT
  } cycKind_t;

endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                selN,
  input  logic                selHi,
  input  logic                selLoN,
  input  logic                procStrobeN,
  input  logic                ctrlStrobeN,
  input  logic                advanceN,
  input  logic                globalWrN,
  input  logic                laneWrEnN,
  input  logic [LANE_CNT-1:0] laneWrN,
  input  logic                sleep,
  output ctlStrobes_t         strobes,
  output logic                readActive
);

  logic                selected;
  logic                procTaken;
  logic [LANE_CNT-1:0] laneMaskReq;
  logic                wantWrite;
  cycKind_t            kind;
  logic                burstOpen;
  logic                burstWrite;

  assign selected  = ~selN & selHi & ~selLoN;
  assign procTaken = ~procStrobeN & ~selN;

  // Global write overrides the lane enables; an empty mask is a read.
  always_comb begin
    if (!globalWrN)      laneMaskReq = '1;
    else if (!laneWrEnN) laneMaskReq = ~laneWrN;
    else                 laneMaskReq = '0;
  end
  assign wantWrite = |laneMaskReq;

  // Cycle classification, strobe priority first.
  always_comb begin
    if (sleep)            kind = CYC_IDLE;
    else if (procTaken)   kind = selected ? CYC_OPEN_PROC : CYC_DESEL;
    else if (!ctrlStrobeN) kind = selected ? CYC_OPEN_CTRL : CYC_DESEL;
    else if (!burstOpen)  kind = CYC_IDLE;
    else if (!advanceN)   kind = CYC_STEP;
    else                  kind = CYC_WAIT;
  end

  always_comb begin
    strobes.loadBase  = (kind == CYC_OPEN_PROC) || (kind == CYC_OPEN_CTRL);
    strobes.stepCount = (kind == CYC_STEP);
    strobes.writeNow  = wantWrite &&
                        ((kind == CYC_OPEN_CTRL) || (kind == CYC_STEP) || (kind == CYC_WAIT));
    strobes.laneSel   = laneMaskReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOpen  <= 1'b0;
      burstWrite <= 1'b0;
    end else begin
      unique case (kind)
        CYC_OPEN_PROC: begin
          burstOpen  <= 1'b1;
          burstWrite <= 1'b0;
        end
        CYC_OPEN_CTRL, CYC_STEP, CYC_WAIT: begin
          burstOpen  <= 1'b1;
          burstWrite <= wantWrite;
        end
        default: begin
          burstOpen  <= 1'b0;
          burstWrite <= 1'b0;
        end
      endcase
    end
  end

  assign readActive = burstOpen & ~burstWrite;

endmodule

// File: rtl/fts_datapath.sv
module fts_datapath
  import fts_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 8,
  localparam int WORD_W = LANE_CNT * (BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linearMode,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [WORD_W-1:0] dataIn,
  input  ctlStrobes_t       strobes,
  output logic [WORD_W-1:0] readWord
);

  localparam int LANE_W   = BYTE_W + 1;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int PAR_BASE = LANE_CNT * BYTE_W;
  localparam int HI_W     = ADDR_W - BURST_BITS;

  logic [HI_W-1:0]       baseHi;
  logic [BURST_BITS-1:0] startLo;
  logic [BURST_BITS-1:0] beatCnt;
  logic [BURST_BITS-1:0] nextCnt;
  logic [ADDR_W-1:0]     curAddr;
  logic [ADDR_W-1:0]     effAddr;

  // Burst order: linear adds the beat count, interleaved XORs it.
  function automatic logic [BURST_BITS-1:0] burstOffset(
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] beat,
    input logic                  lin
  );
    return lin ? (start + beat) : (start ^ beat);
  endfunction

  assign nextCnt = beatCnt + 1'b1;
  assign curAddr = {baseHi, burstOffset(startLo, beatCnt, linearMode)};

  always_comb begin
    if (strobes.loadBase)       effAddr = addrIn;
    else if (strobes.stepCount) effAddr = {baseHi, burstOffset(startLo, nextCnt, linearMode)};
    else                        effAddr = curAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi  <= '0;
      startLo <= '0;
      beatCnt <= '0;
    end else if (strobes.loadBase) begin
      baseHi  <= addrIn[ADDR_W-1:BURST_BITS];
      startLo <= addrIn[BURST_BITS-1:0];
      beatCnt <= '0;
    end else if (strobes.stepCount) begin
      beatCnt <= nextCnt;
    end
  end

  // One storage array per lane, so each lane write is independent.
  for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneIn;
    logic [LANE_W-1:0] laneOut;

    assign laneIn = {dataIn[PAR_BASE + g], dataIn[g*BYTE_W +: BYTE_W]};

    always_ff @(posedge clk) begin
      if (strobes.writeNow && strobes.laneSel[g]) laneMem[effAddr] <= laneIn;
    end

    assign laneOut                      = laneMem[curAddr];
    assign readWord[g*BYTE_W +: BYTE_W] = laneOut[BYTE_W-1:0];
    assign readWord[PAR_BASE + g]       = laneOut[BYTE_W];
  end

endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram
  import fts_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 8,
  localparam int WORD_W = LANE_CNT * (BYTE_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                selN,
  input  logic                selHi,
  input  logic                selLoN,
  input  logic                procStrobeN,
  input  logic                ctrlStrobeN,
  input  logic                advanceN,
  input  logic                globalWrN,
  input  logic                laneWrEnN,
  input  logic [LANE_CNT-1:0] laneWrN,
  input  logic                linearMode,
  input  logic                outEnN,
  input  logic                sleep,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   dataIn,
  output logic [WORD_W-1:0]   dataOut,
  output logic                dataOutEn
);

  ctlStrobes_t       strobes;
  logic              readActive;
  logic [WORD_W-1:0] readWord;

  fts_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .selN        (selN),
    .selHi       (selHi),
    .selLoN      (selLoN),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advanceN    (advanceN),
    .globalWrN   (globalWrN),
    .laneWrEnN   (laneWrEnN),
    .laneWrN     (laneWrN),
    .sleep       (sleep),
    .strobes     (strobes),
    .readActive  (readActive)
  );

  fts_datapath #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .linearMode (linearMode),
    .addrIn     (addr),
    .dataIn     (dataIn),
    .strobes    (strobes),
    .readWord   (readWord)
  );

  // Output enable and sleep gate the flow-through data without a clock.
  assign dataOutEn = readActive & ~outEnN & ~sleep;
  assign dataOut   = dataOutEn ? readWord : '0;

endmodule

// File: rtl/fts_burst_sram_chk.sv
module fts_burst_sram_chk #(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              selN,
  input logic              selHi,
  input logic              selLoN,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              advanceN,
  input logic              globalWrN,
  input logic              laneWrEnN,
  input logic              outEnN,
  input logic              sleep,
  input logic [WORD_W-1:0] dataOut,
  input logic              dataOutEn
);

  logic chipSel;
  assign chipSel = ~selN & selHi & ~selLoN;

  // R1: a controller strobe without full selection closes the bus
  p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && !(!procStrobeN && !selN) && !chipSel && !sleep) |=> !dataOutEn);

  // R3: a selected processor strobe always yields a read
  p_proc_reads_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && chipSel && !sleep) |=> (dataOutEn || outEnN || sleep));

  // R9: a controller-strobe write keeps the bus off
  p_write_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobeN && !ctrlStrobeN && chipSel && !globalWrN && !sleep) |=> !dataOutEn);

  // R6: a read wait cycle keeps the same word on the bus
  p_wait_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataOutEn && procStrobeN && ctrlStrobeN && advanceN && globalWrN && laneWrEnN && !sleep)
    |=> (!dataOutEn || $stable(dataOut)));

  // R10: a sleep edge closes the burst
  p_sleep_closes_r10: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> !dataOutEn);

endmodule

bind fts_burst_sram fts_burst_sram_chk #(.WORD_W(WORD_W)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .selN        (selN),
  .selHi       (selHi),
  .selLoN      (selLoN),
  .procStrobeN (procStrobeN),
  .ctrlStrobeN (ctrlStrobeN),
  .advanceN    (advanceN),
  .globalWrN   (globalWrN),
  .laneWrEnN   (laneWrEnN),
  .outEnN      (outEnN),
  .sleep       (sleep),
  .dataOut     (dataOut),
  .dataOutEn   (dataOutEn)
);

// File: tb/test_fts_burst_sram.sv
module test_fts_burst_sram;

  localparam int ADDR_W = 6;
  localparam int WORD_W = 36;

  logic              clk = 1'b0;
  logic              rstN;
  logic              selN, selHi, selLoN;
  logic              procStrobeN, ctrlStrobeN, advanceN;
  logic              globalWrN, laneWrEnN;
  logic [3:0]        laneWrN;
  logic              linearMode, outEnN, sleep;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] dataIn;
  logic [WORD_W-1:0] dataOut;
  logic              dataOutEn;

  int nChecks = 0;
  int nFail   = 0;
  logic [WORD_W-1:0] refMem [1 << ADDR_W];

  always #5 clk = ~clk;

  fts_burst_sram #(.ADDR_W(ADDR_W)) i_fts_burst_sram (
    .clk(clk), .rstN(rstN), .selN(selN), .selHi(selHi), .selLoN(selLoN),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .globalWrN(globalWrN), .laneWrEnN(laneWrEnN), .laneWrN(laneWrN),
    .linearMode(linearMode), .outEnN(outEnN), .sleep(sleep), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  function automatic logic [WORD_W-1:0] pat(int a, int s);
    return {4'(a + s), 8'(s * 3 + 1), 8'(a * 5 + s), 8'(8'hA5 ^ 8'(s)), 8'(a)};
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advanceN = 1'b1;
    globalWrN = 1'b1; laneWrEnN = 1'b1; laneWrN = 4'hF;
    selN = 1'b0; selHi = 1'b1; selLoN = 1'b0; sleep = 1'b0; outEnN = 1'b0;
    dataIn = '0;
  endtask

  task automatic chkVal(string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkRead(string req, int a);
    chkVal({req, " enable"}, WORD_W'(dataOutEn), WORD_W'(1));
    chkVal({req, " data"}, dataOut, refMem[a]);
  endtask

  task automatic chkOff(string req);
    chkVal({req, " enable"}, WORD_W'(dataOutEn), WORD_W'(0));
    chkVal({req, " data"}, dataOut, '0);
  endtask

  // Open a burst with the controller strobe.
  task automatic ctrlOpen(int a, bit wr, logic [WORD_W-1:0] d);
    idle();
    ctrlStrobeN = 1'b0; addr = ADDR_W'(a); globalWrN = ~wr; dataIn = d;
    tick();
    if (wr) refMem[a] = d;
  endtask

  // Burst step (adv=1) or wait (adv=0); expAddr is the word the requirement names.
  task automatic burstCyc(bit adv, bit wr, logic [WORD_W-1:0] d, int expAddr);
    idle();
    advanceN = ~adv; globalWrN = ~wr; dataIn = d;
    tick();
    if (wr) refMem[expAddr] = d;
  endtask

  task automatic t_reset();
    chkOff("R11 after reset");
  endtask

  task automatic t_write_linear();
    linearMode = 1'b1;
    ctrlOpen(4, 1'b1, pat(4, 1));
    chkOff("R9 write cycle");
    burstCyc(1'b1, 1'b1, pat(5, 1), 5);
    burstCyc(1'b1, 1'b1, pat(6, 1), 6);
    burstCyc(1'b1, 1'b1, pat(7, 1), 7);
    chkOff("R4 write burst");
    ctrlOpen(4, 1'b0, '0);
    chkRead("R4 read open", 4);
    for (int k = 1; k < 4; k++) begin
      burstCyc(1'b1, 1'b0, '0, 4 + k);
      chkRead("R5 linear from 4", 4 + k);
    end
  endtask

  task automatic t_read_interleaved();
    linearMode = 1'b0;
    ctrlOpen(6, 1'b0, '0);
    chkRead("R8 same-period read", 6);
    burstCyc(1'b1, 1'b0, '0, 7); chkRead("R5 interleaved beat1", 7);
    burstCyc(1'b1, 1'b0, '0, 4); chkRead("R5 interleaved beat2", 4);
    burstCyc(1'b1, 1'b0, '0, 5); chkRead("R5 interleaved beat3", 5);
    burstCyc(1'b1, 1'b0, '0, 6); chkRead("R5 interleaved wrap", 6);
  endtask

  task automatic t_read_linear();
    linearMode = 1'b1;
    ctrlOpen(5, 1'b0, '0);
    chkRead("R5 linear start 5", 5);
    burstCyc(1'b1, 1'b0, '0, 6); chkRead("R5 linear beat1", 6);
    burstCyc(1'b1, 1'b0, '0, 7); chkRead("R5 linear beat2", 7);
    burstCyc(1'b1, 1'b0, '0, 4); chkRead("R5 linear wrap in group", 4);
  endtask

  task automatic t_proc_then_write();
    ctrlOpen(9, 1'b1, pat(9, 2));
    idle();
    procStrobeN = 1'b0; addr = ADDR_W'(9); globalWrN = 1'b0; dataIn = pat(9, 77);
    tick();
    chkRead("R3 proc strobe reads despite write", 9);
    burstCyc(1'b0, 1'b1, pat(9, 3), 9);
    chkOff("R6 wait-cycle write");
    ctrlOpen(9, 1'b0, '0);
    chkRead("R6 write after proc read", 9);
  endtask

  task automatic t_lanes();
    logic [WORD_W-1:0] nd;
    logic [3:0]        lanesLow;
    ctrlOpen(12, 1'b1, pat(12, 4));
    nd = pat(12, 9);
    lanesLow = 4'b1010;
    idle();
    ctrlStrobeN = 1'b0; addr = ADDR_W'(12); laneWrEnN = 1'b0; laneWrN = lanesLow; dataIn = nd;
    tick();
    for (int n = 0; n < 4; n++) begin
      if (!lanesLow[n]) begin
        refMem[12][8*n +: 8] = nd[8*n +: 8];
        refMem[12][32 + n]   = nd[32 + n];
      end
    end
    idle();
    ctrlStrobeN = 1'b0; addr = ADDR_W'(12); laneWrEnN = 1'b0; laneWrN = 4'hF; dataIn = pat(12, 55);
    tick();
    chkRead("R7 lane merge and empty mask reads", 12);
  endtask

  task automatic t_wait();
    linearMode = 1'b0;
    ctrlOpen(5, 1'b0, '0);
    burstCyc(1'b0, 1'b0, '0, 5); chkRead("R6 wait holds word", 5);
    burstCyc(1'b0, 1'b0, '0, 5); chkRead("R6 second wait", 5);
    burstCyc(1'b1, 1'b0, '0, 4); chkRead("R5 step after wait", 4);
  endtask

  task automatic t_deselect();
    logic [WORD_W-1:0] keep;
    keep = refMem[4];
    idle();
    ctrlStrobeN = 1'b0; selHi = 1'b0; addr = ADDR_W'(4); globalWrN = 1'b0; dataIn = pat(4, 99);
    tick();
    chkOff("R1 secondary high select off");
    idle();
    ctrlStrobeN = 1'b0; selLoN = 1'b1; addr = ADDR_W'(4); globalWrN = 1'b0; dataIn = pat(4, 98);
    tick();
    chkOff("R1 secondary low select off");
    burstCyc(1'b1, 1'b0, '0, 0);
    chkOff("R1 no step while deselected");
    ctrlOpen(4, 1'b0, '0);
    chkVal("R1 deselect wrote nothing", dataOut, keep);
  endtask

  task automatic t_primary_off();
    linearMode = 1'b1;
    ctrlOpen(4, 1'b0, '0);
    idle();
    selN = 1'b1; procStrobeN = 1'b0; addr = ADDR_W'(20); advanceN = 1'b0;
    tick();
    chkRead("R2 proc strobe ignored, burst steps", 5);
  endtask

  task automatic t_outen();
    ctrlOpen(6, 1'b0, '0);
    chkRead("R9 base read", 6);
    #1 outEnN = 1'b1;
    #1 chkOff("R9 output enable high");
    outEnN = 1'b0;
    #1 chkRead("R9 output enable back", 6);
  endtask

  task automatic t_sleep();
    ctrlOpen(6, 1'b0, '0);
    idle();
    sleep = 1'b1;
    #1 chkOff("R10 sleep gates at once");
    ctrlStrobeN = 1'b0; addr = ADDR_W'(6); globalWrN = 1'b0; dataIn = pat(6, 66);
    tick();
    chkOff("R10 asleep");
    idle();
    tick();
    chkOff("R10 burst closed after wake");
    ctrlOpen(6, 1'b0, '0);
    chkRead("R10 contents kept", 6);
  endtask

  initial begin
    idle();
    linearMode = 1'b1;
    addr = '0;
    rstN = 1'b0;
    fork
      begin
        repeat (3) @(posedge clk);
        #2 rstN = 1'b1;
        t_reset();
        tick();
        t_reset();
        t_write_linear();
        t_read_interleaved();
        t_read_linear();
        t_proc_then_write();
        t_lanes();
        t_wait();
        t_deselect();
        t_primary_off();
        t_outen();
        t_sleep();
      end
      begin
        repeat (100000) @(posedge clk);
        nChecks++;
        nFail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule